// File: doc/BRIEF.md
# Interrupt enable and request registers

This block holds two matching 16-bit interrupt words for a processor: an enable mask and a pending-request word. Each source has the same bit position in both words. Software never overwrites either word. A write carries a mode flag in its top bit. A write in set mode turns on every bit that is written as 1. A write in clear mode turns off every bit that is written as 1. Bits written as 0 are left alone in both modes.

Fourteen source bits occupy positions 0 to 13. Hardware sources raise their request bits with single-cycle pulses. Bit 2 is the exception: it has no hardware input and is raised only by software. Bit 14 of the enable word is a global gate. The single interrupt line is high when this gate is on and at least one source is both enabled and pending. Software can read both words at any time.

Top module: `intr_regpair`

## Requirements
- R1: A write with bit 15 = 1 sets every target bit whose data bit is 1. In the enable word this covers bits 0 to 14; in the request word it covers bits 0 to 13. The new value appears on the read port one clock after the write.
- R2: A write with bit 15 = 0 clears every target bit whose data bit is 1, one clock after the write.
- R3: Data bits written as 0 leave the matching register bits unchanged in both modes. With no write and no hardware pulse, both words hold their value.
- R4: Bit 14 is the global interrupt gate and is stored only in the enable word. The request word always reads bit 14 as 0, even after a set write with bit 14 = 1.
- R5: A pulse on `hw_src[i]` (i ≠ 2) sets request bit i one clock later.
- R6: `hw_src[2]` has no effect. Request bit 2 can be raised only by a set write to the request word.
- R7: If a clear write and a hardware pulse reach the same request bit in the same cycle, the bit ends up set.
- R8: `irq_out` is 1 exactly when enable bit 14 is 1 and, for some i in 0..13, enable bit i and request bit i are both 1. It is computed from the stored words with no extra delay.
- R9: Both read ports return bit 15 as 0.
- R10: A synchronous, active-high reset clears both words, so `irq_out` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_wr | input | 1 | Write strobe for the enable word |
| req_wr | input | 1 | Write strobe for the request word |
| wr_data | input | 16 | Write word: bit 15 selects set/clear mode, bits 14..0 select the bits to change |
| hw_src | input | 14 | Hardware request pulses, one per source |
| en_rd | output | 16 | Enable word read-back |
| req_rd | output | 16 | Request word read-back |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with its default of fourteen sources, with bit 2 as the software-only bit. At this size every source bit and the global gate can be driven one at a time, in both set and clear mode, on both words. This covers the full bit map, including the ignored hardware input at bit 2 and the clash between a clear write and a hardware pulse. A long pseudo-random phase then overlaps writes to both words with hardware pulses. After every cycle it compares both read ports and the interrupt line against an arithmetic model.

// File: rtl/intr_regpair_pkg.sv
package intr_regpair_pkg;
    // number of interrupt sources in the default build
    localparam int unsigned SRC_NUM_DEF = 14;
    // source that only software can raise
    localparam int unsigned SW_ONLY_DEF = 2;

    // pure set/clear update, no hardware term
    function automatic logic [SRC_NUM_DEF:0] setclr_apply(
        input logic [SRC_NUM_DEF:0] cur,
        input logic                 set_mode,
        input logic [SRC_NUM_DEF:0] sel
    );
        setclr_apply = set_mode ? (cur | sel) : (cur & ~sel);
    endfunction
endpackage

// File: rtl/intr_setclr_reg.sv
module intr_setclr_reg #(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         set_mode,
    input  logic [W-1:0] wr_bits,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (set_mode) st_d.bits = st_q.bits | wr_bits;
            else          st_d.bits = st_q.bits & ~wr_bits;
        end
        // hardware set applied last so it beats a clear
        st_d.bits = st_d.bits | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q = st_q.bits;

    // R1
    set_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && set_mode) |=> ((q & $past(wr_bits)) == $past(wr_bits)));
    // R2
    clr_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !set_mode && hw_set == '0) |=> ((q & $past(wr_bits)) == '0));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && hw_set == '0) |=> $stable(q));
    // R7
    hw_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/intr_irq_gate.sv
module intr_irq_gate #(
    parameter int unsigned N = 14
) (
    input  logic         master,
    input  logic [N-1:0] en,
    input  logic [N-1:0] req,
    output logic         irq
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_hit
        assign hit[i] = en[i] & req[i];
    end

    assign irq = master & (|hit);
endmodule

// File: rtl/intr_regpair.sv
module intr_regpair
    import intr_regpair_pkg::*;
#(
    parameter int unsigned SRC_W   = SRC_NUM_DEF,
    parameter int unsigned SW_ONLY = SW_ONLY_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_wr,
    input  logic                 req_wr,
    input  logic [SRC_W+1:0]     wr_data,
    input  logic [SRC_W-1:0]     hw_src,
    output logic [SRC_W+1:0]     en_rd,
    output logic [SRC_W+1:0]     req_rd,
    output logic                 irq_out
);
    localparam int unsigned MODE_BIT   = SRC_W + 1;
    localparam int unsigned MASTER_BIT = SRC_W;

    logic [SRC_W:0]   en_q;
    logic [SRC_W-1:0] req_q;
    logic [SRC_W-1:0] hw_mask;
    logic [SRC_W-1:0] hw_eff;

    // the software-only source has no hardware path
    for (genvar i = 0; i < SRC_W; i++) begin : g_mask
        if (i == SW_ONLY) begin : g_sw
            assign hw_mask[i] = 1'b0;
        end else begin : g_hw
            assign hw_mask[i] = 1'b1;
        end
    end
    assign hw_eff = hw_src & hw_mask;

    intr_setclr_reg #(.W(SRC_W + 1)) u_en (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (en_wr),
        .set_mode (wr_data[MODE_BIT]),
        .wr_bits  (wr_data[SRC_W:0]),
        .hw_set   ('0),
        .q        (en_q)
    );

    intr_setclr_reg #(.W(SRC_W)) u_req (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (req_wr),
        .set_mode (wr_data[MODE_BIT]),
        .wr_bits  (wr_data[SRC_W-1:0]),
        .hw_set   (hw_eff),
        .q        (req_q)
    );

    intr_irq_gate #(.N(SRC_W)) u_gate (
        .master (en_q[MASTER_BIT]),
        .en     (en_q[SRC_W-1:0]),
        .req    (req_q),
        .irq    (irq_out)
    );

    assign en_rd  = {1'b0, en_q};
    assign req_rd = {2'b00, req_q};

    // R4
    req_master_zero_chk: assert property (@(posedge clk) disable iff (rst)
        req_rd[MASTER_BIT] == 1'b0);
    // R5
    hw_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_eff != '0) |=> ((req_rd[SRC_W-1:0] & $past(hw_eff)) == $past(hw_eff)));
    // R6
    sw_only_chk: assert property (@(posedge clk) disable iff (rst)
        !req_wr |=> !$rose(req_rd[SW_ONLY]));
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out == (en_rd[MASTER_BIT] && ((en_rd[SRC_W-1:0] & req_rd[SRC_W-1:0]) != '0)));
    // R9
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !en_rd[MODE_BIT] && !req_rd[MODE_BIT]);
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (en_rd == '0 && req_rd == '0 && !irq_out));
endmodule

// File: tb/sim_intr_regpair.sv
module sim_intr_regpair;
    logic        clk = 1'b0;
    logic        rst;
    logic        en_wr, req_wr;
    logic [15:0] wr_data;
    logic [13:0] hw_src;
    logic [15:0] en_rd, req_rd;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [14:0] en_m;
    logic [13:0] req_m;

    always #5 clk = ~clk;

    intr_regpair u0 (
        .clk(clk), .rst(rst), .en_wr(en_wr), .req_wr(req_wr),
        .wr_data(wr_data), .hw_src(hw_src),
        .en_rd(en_rd), .req_rd(req_rd), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic model_irq();
        return en_m[14] && ((en_m[13:0] & req_m) != 14'd0);
    endfunction

    // one cycle: drive at negedge, update model, sample 1 ns after edge
    task automatic cyc(input logic ew, input logic rw, input logic [15:0] d,
                       input logic [13:0] hw, input string tag);
        @(negedge clk);
        en_wr = ew; req_wr = rw; wr_data = d; hw_src = hw;
        @(posedge clk);
        if (ew) en_m = d[15] ? (en_m | d[14:0]) : (en_m & ~d[14:0]);
        if (rw) req_m = d[15] ? (req_m | d[13:0]) : (req_m & ~d[13:0]);
        req_m = req_m | (hw & 14'h3ffb);
        #1;
        chk({tag, " en"},  en_rd,  {1'b0, en_m});
        chk({tag, " req"}, req_rd, {2'b00, req_m});
        chk({tag, " irq"}, {15'd0, irq_out}, {15'd0, model_irq()});
        en_wr = 0; req_wr = 0; hw_src = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        en_m = '0; req_m = '0;
        chk("R10 en",  en_rd,  16'h0);
        chk("R10 req", req_rd, 16'h0);
        chk("R10 irq", {15'd0, irq_out}, 16'h0);
    endtask

    initial begin
        logic [31:0] lfsr;
        rst = 1; en_wr = 0; req_wr = 0; wr_data = '0; hw_src = '0;
        en_m = '0; req_m = '0;
        repeat (2) @(posedge clk);
        do_reset();

        // R1/R2/R9: single-bit set and clear on the enable word, bits 0..14
        for (int i = 0; i < 15; i++) begin
            cyc(1, 0, 16'h8000 | (16'd1 << i), '0, "R1 en set");
            cyc(1, 0, (16'd1 << i), '0, "R2 en clr");
        end
        // R1/R2/R4: request word, bits 0..14 (bit 14 must stay 0)
        for (int i = 0; i < 15; i++) begin
            cyc(0, 1, 16'h8000 | (16'd1 << i), '0, "R1 R4 req set");
            cyc(0, 1, (16'd1 << i), '0, "R2 req clr");
        end
        // R3: zero data bits untouched in both modes
        cyc(1, 1, 16'hffff, '0, "R1 all set");
        cyc(1, 1, 16'h8000, '0, "R3 set none");
        cyc(1, 1, 16'h0000, '0, "R3 clr none");
        cyc(0, 0, 16'h5555, '0, "R3 hold");
        cyc(1, 1, 16'h2aaa, '0, "R3 R2 partial clr");
        do_reset();

        // R5/R6: each hardware source alone
        for (int i = 0; i < 14; i++) begin
            cyc(0, 0, '0, 14'd1 << i, (i == 2) ? "R6 hw ignored" : "R5 hw set");
            cyc(0, 1, 16'h3fff, '0, "R2 req clr all");
        end
        // R6: software raises bit 2
        cyc(0, 1, 16'h8004, '0, "R6 sw set");
        // R7: clear write and pulse on the same bit
        cyc(0, 1, 16'h8020, '0, "R1 req b5");
        cyc(0, 1, 16'h0020, 14'h0020, "R7 hw beats clr");

        // R8: irq for each source, gate on and off
        do_reset();
        for (int i = 0; i < 14; i++) begin
            cyc(0, 1, 16'h8000 | (16'd1 << i), '0, "R8 req");
            cyc(1, 0, 16'h8000 | (16'd1 << i), '0, "R8 en no gate");
            cyc(1, 0, 16'hc000, '0, "R8 gate on");
            cyc(1, 0, 16'h4000, '0, "R8 gate off");
            cyc(1, 1, 16'h3fff, '0, "R8 clr");
        end

        // mixed pseudo-random traffic
        lfsr = 32'h1ace_b00c;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(lfsr[3], lfsr[7], lfsr[31:16], (lfsr[11] ? lfsr[29:16] & lfsr[13:0] : 14'd0),
                "R1 R2 R5 R7 R8 mix");
        end
        do_reset();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule